// File: doc/BRIEF.md
# Prescaled One-Shot/Periodic Down-Timer

This block is a 16-bit down-counter preceded by an 8-bit prescaler, which together give a 24-bit range of timeout intervals. Software arms it by writing its enable bit, chooses between a single run and repeated runs with a mode input, and supplies a load value and a prescale value. Each time the count reaches zero the block raises a sticky timeout flag. A mask input decides whether that flag also drives the interrupt. A separate enable gates a trigger pulse exactly one clock wide.

In single-run mode the block clears its own enable when it times out and leaves the count at zero. In repeating mode, the cycle after the count reads zero, the block reloads both the load value and the prescale value and keeps running. A strobe can push a new load value into a running counter at once. A stall input, qualified by a stall enable, freezes all progress while it is asserted.

Top module: `pdt_timer`

## Requirements
- R1: After reset the count reads 0, the enable readback is 0, and the raw flag, masked flag, interrupt and trigger are all 0.
- R2: An enable write of 1 (`en_wr_i`=1, `en_val_i`=1) while stopped sets the enable and loads the count with `load_val_i` and the prescaler with `pre_val_i` at the next edge. An enable write of 1 while running is ignored. An enable write of 0 stops the timer and leaves the count unchanged.
- R3: With prescale value P, the count steps down by one every P+1 clocks. Counting from the start, the count reads L - floor(k/(P+1)) k clocks after arming, until it reaches 0.
- R4: In repeating mode (`mode_i`=1) the count reads 0 for exactly one clock. It then reloads the load value and the prescale value, so the period is L*(P+1)+1 clocks for a load value L of 1 or more.
- R5: In single-run mode (`mode_i`=0), at the edge where the count becomes 0 the enable readback drops to 0 and the count stays at 0.
- R6: The raw timeout flag sets at the edge where the count steps down to 0 and holds until a `clr_i` strobe. A clear that coincides with a timeout leaves the flag set.
- R7: The masked flag and the interrupt equal the raw flag ANDed with `irq_mask_i`.
- R8: The trigger is high for exactly one clock, in the first clock in which the count reads 0 after a timeout, and only when `trig_en_i` is 1.
- R9: A `load_wr_i` strobe while running puts `load_val_i` into the count at the next edge and restarts the prescaler from `pre_val_i`. While stopped, the strobe leaves the count unchanged.
- R10: While `stall_en_i` and `stall_i` are both 1, the count, prescaler and reload all hold, and no timeout or trigger occurs. `stall_i` has no effect when `stall_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_wr_i | input | 1 | Enable-bit write strobe |
| en_val_i | input | 1 | Value written to the enable bit |
| mode_i | input | 1 | 0 single run, 1 repeating |
| load_val_i | input | 16 | Load value |
| load_wr_i | input | 1 | Load value was just written |
| pre_val_i | input | 8 | Prescale value |
| trig_en_i | input | 1 | Trigger pulse enable |
| irq_mask_i | input | 1 | Interrupt mask (1 = enabled) |
| clr_i | input | 1 | Clear strobe for the timeout flag |
| stall_en_i | input | 1 | Allows the stall input to freeze the timer |
| stall_i | input | 1 | Stall request |
| cnt_o | output | 16 | Current count |
| run_o | output | 1 | Enable-bit readback |
| tmo_raw_o | output | 1 | Sticky raw timeout flag |
| tmo_masked_o | output | 1 | Masked timeout flag |
| irq_o | output | 1 | Interrupt |
| trig_o | output | 1 | One-clock trigger pulse |

## Verification
The bench sweeps every load value from 1 to 4 against every prescale value from 0 to 3 in both modes. It predicts each cycle's count from the elapsed clocks. This exposes an off-by-one prescaler, which would stretch or shrink every step, and a skipped or doubled zero cycle, which would shift every later period. Stall sweeps freeze the timer on every third clock, including clocks spent at zero, so a design that reloads or pulses the trigger while frozen shows a count or trigger out of step. Directed cases apply a clear in the same clock as a timeout, which a clear-wins design would drop, and a load write into a running and a stopped counter. They also write the enable while running, which a design that re-arms would answer with a jump in the count.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    typedef enum logic {
        PDT_ONESHOT  = 1'b0,
        PDT_PERIODIC = 1'b1
    } pdt_mode_e;

    localparam int unsigned PDT_CNT_W = 16;
    localparam int unsigned PDT_PRE_W = 8;
endpackage

// File: rtl/pdt_prescale.sv
module pdt_prescale #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [PRE_W-1:0] pre_val_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.pre = pre_val_i;
        end else if (run_i && !hold_i) begin
            if (s_q.pre == '0) s_d.pre = pre_val_i;
            else               s_d.pre = s_q.pre - PRE_W'(1);
        end
    end

    assign tick_o = run_i && !hold_i && (s_q.pre == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R10: a frozen prescaler keeps its value
    assert_pre_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !load_i) |=> $stable(s_q.pre));

    // R3: after a tick the prescaler restarts from the prescale value
    assert_pre_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !load_i) |=> (s_q.pre == $past(pre_val_i)));
endmodule

// File: rtl/pdt_count.sv
module pdt_count
    import pdt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             mode_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             hit_o,
    output logic             pre_load_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    pdt_mode_e  mode;

    assign mode = pdt_mode_e'(mode_i);

    always_comb begin
        s_d        = s_q;
        hit_o      = 1'b0;
        pre_load_o = 1'b0;
        if (en_wr_i && !en_val_i) begin
            s_d.run = 1'b0;
        end else if (!s_q.run) begin
            if (en_wr_i && en_val_i) begin
                s_d.run    = 1'b1;
                s_d.cnt    = load_val_i;
                pre_load_o = 1'b1;
            end
        end else if (load_wr_i) begin
            s_d.cnt    = load_val_i;
            pre_load_o = 1'b1;
        end else if (!hold_i) begin
            if (s_q.cnt == '0) begin
                s_d.cnt    = load_val_i;
                pre_load_o = 1'b1;
            end else if (tick_i) begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) begin
                    hit_o = 1'b1;
                    if (mode == PDT_ONESHOT) s_d.run = 1'b0;
                end
            end
        end
    end

    assign cnt_o = s_q.cnt;
    assign run_o = s_q.run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R2: arming loads the count
    assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.run && en_wr_i && en_val_i) |=> (s_q.run && s_q.cnt == $past(load_val_i)));

    // R2: a stop write keeps the count
    assert_stop_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_wr_i && !en_val_i) |=> (!s_q.run && $stable(s_q.cnt)));

    // R9: a stopped counter ignores load writes
    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.run && !en_wr_i) |=> $stable(s_q.cnt));

    // R9: a load write into a running counter takes effect next clock
    assert_load_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && load_wr_i && !en_wr_i) |=> (s_q.cnt == $past(load_val_i)));

    // R10: frozen count
    assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && hold_i && !load_wr_i && !en_wr_i) |=> $stable(s_q.cnt));

    // R4: zero is followed by a reload
    assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && s_q.cnt == '0 && !hold_i && !load_wr_i && !en_wr_i)
        |=> (s_q.cnt == $past(load_val_i)));

    // R5: single-run clears its enable on timeout
    assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_o && mode == PDT_ONESHOT) |=> (!s_q.run && s_q.cnt == '0));
endmodule

// File: rtl/pdt_flags.sv
module pdt_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic trig_en_i,
    input  logic irq_mask_i,
    input  logic clr_i,
    output logic raw_o,
    output logic masked_o,
    output logic irq_o,
    output logic trig_o
);
    typedef struct packed {
        logic raw;
        logic trig;
    } flag_state_t;

    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_i)      s_d.raw = 1'b1;
        else if (clr_i) s_d.raw = 1'b0;
        s_d.trig = hit_i && trig_en_i;
    end

    assign raw_o    = s_q.raw;
    assign masked_o = s_q.raw && irq_mask_i;
    assign irq_o    = masked_o;
    assign trig_o   = s_q.trig;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R6: flag is sticky without a clear
    assert_raw_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.raw && !clr_i) |=> s_q.raw);

    // R6: a timeout beats a simultaneous clear
    assert_clr_collide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> s_q.raw);

    // R8: pulse is a single clock wide
    assert_trig_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.trig |=> !s_q.trig);

    // R8: no pulse when the trigger is disabled
    assert_trig_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_en_i |=> !s_q.trig);
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int unsigned CNT_W = PDT_CNT_W,
    parameter int unsigned PRE_W = PDT_PRE_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             load_wr_i,
    input  logic [PRE_W-1:0] pre_val_i,
    input  logic             trig_en_i,
    input  logic             irq_mask_i,
    input  logic             clr_i,
    input  logic             stall_en_i,
    input  logic             stall_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             tmo_raw_o,
    output logic             tmo_masked_o,
    output logic             irq_o,
    output logic             trig_o
);
    logic hold;
    logic tick;
    logic hit;
    logic pre_load;

    assign hold = stall_en_i && stall_i;

    pdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_o),
        .hold_i    (hold),
        .load_i    (pre_load),
        .pre_val_i (pre_val_i),
        .tick_o    (tick)
    );

    pdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_wr_i    (en_wr_i),
        .en_val_i   (en_val_i),
        .mode_i     (mode_i),
        .load_wr_i  (load_wr_i),
        .load_val_i (load_val_i),
        .tick_i     (tick),
        .hold_i     (hold),
        .cnt_o      (cnt_o),
        .run_o      (run_o),
        .hit_o      (hit),
        .pre_load_o (pre_load)
    );

    pdt_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hit_i      (hit),
        .trig_en_i  (trig_en_i),
        .irq_mask_i (irq_mask_i),
        .clr_i      (clr_i),
        .raw_o      (tmo_raw_o),
        .masked_o   (tmo_masked_o),
        .irq_o      (irq_o),
        .trig_o     (trig_o)
    );

    // R8: the pulse coincides with a zero count
    assert_trig_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> (cnt_o == '0 && tmo_raw_o));

    // R3: a tick on a nonzero count steps it down by one
    assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && tick && cnt_o != '0 && !load_wr_i && !en_wr_i)
        |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
endmodule

// File: tb/pdt_timer_tb_top.sv
`timescale 1ns/1ps
module pdt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_wr, en_val, mode, load_wr, trig_en, irq_mask, clr, stall_en, stall;
    logic [15:0] load_val;
    logic [7:0]  pre_val;
    logic [15:0] cnt;
    logic        run, raw, masked, irq, trig;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pdt_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_wr_i(en_wr), .en_val_i(en_val), .mode_i(mode),
        .load_val_i(load_val), .load_wr_i(load_wr), .pre_val_i(pre_val),
        .trig_en_i(trig_en), .irq_mask_i(irq_mask), .clr_i(clr),
        .stall_en_i(stall_en), .stall_i(stall),
        .cnt_o(cnt), .run_o(run), .tmo_raw_o(raw), .tmo_masked_o(masked),
        .irq_o(irq), .trig_o(trig)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic stop_clear();
        int prev;
        prev = int'(cnt);
        en_wr = 1'b1; en_val = 1'b0;
        step();
        en_wr = 1'b0;
        chk(run == 1'b0, "R2 stop run", int'(run), 0);
        chk(int'(cnt) == prev, "R2 stop keeps count", int'(cnt), prev);
        clr = 1'b1;
        step();
        clr = 1'b0;
        chk(raw == 1'b0, "R6 clear", int'(raw), 0);
    endtask

    task automatic arm(input int l, input int p, input bit per);
        load_val = 16'(l); pre_val = 8'(p); mode = per;
        en_wr = 1'b1; en_val = 1'b1;
        step();
        en_wr = 1'b0;
    endtask

    task automatic run_case(input int l, input int p, input bit per, input bit ote,
                            input bit msk, input bit sen, input int ncyc);
        int keff, span, period, ph, ecnt;
        bit adv, erun, eraw, etrig;
        trig_en = ote; irq_mask = msk; stall_en = sen; stall = 1'b0;
        arm(l, p, per);
        keff = 0; span = l * (p + 1); period = span + 1; adv = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            ph    = per ? (keff % period) : ((keff > span) ? span : keff);
            ecnt  = (ph == span) ? 0 : l - ph / (p + 1);
            erun  = per ? 1'b1 : (keff < span);
            eraw  = (keff >= span);
            etrig = ote && adv && (ph == span) && (per || keff == span);
            if (sen) chk(int'(cnt) == ecnt, "R10 stall count", int'(cnt), ecnt);
            else if (per) chk(int'(cnt) == ecnt, "R4 periodic count", int'(cnt), ecnt);
            else chk(int'(cnt) == ecnt, "R3 prescaled count", int'(cnt), ecnt);
            chk(run == erun, "R5 enable readback", int'(run), int'(erun));
            chk(raw == eraw, "R6 raw flag", int'(raw), int'(eraw));
            chk(irq == (eraw && msk) && masked == (eraw && msk), "R7 masked irq",
                int'(irq), int'(eraw && msk));
            chk(trig == etrig, "R8 trigger", int'(trig), int'(etrig));
            stall = (c % 3 == 1);
            step();
            adv = !(sen && stall);
            if (adv) keff++;
        end
        stall = 1'b0;
        stop_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        en_wr = 0; en_val = 0; mode = 0; load_wr = 0; trig_en = 0; irq_mask = 0;
        clr = 0; stall_en = 0; stall = 0; load_val = '0; pre_val = '0;
        repeat (3) step();
        chk(cnt == 16'd0 && run == 1'b0, "R1 reset count/enable", int'(cnt), 0);
        chk(raw == 1'b0 && masked == 1'b0 && irq == 1'b0 && trig == 1'b0,
            "R1 reset flags", int'(raw | masked | irq | trig), 0);
        rst_n = 1'b1;
        step();

        // R3 R4 R5: full sweep of small load and prescale values, both modes
        for (int l = 1; l <= 4; l++)
            for (int p = 0; p <= 3; p++)
                for (int m = 0; m <= 1; m++)
                    run_case(l, p, m[0], (l + p) % 2 == 1, m[0], 1'b0,
                             2 * (l * (p + 1) + 1) + 3);

        // R10: stall enabled and stall ignored when disabled
        for (int l = 2; l <= 3; l++)
            for (int p = 0; p <= 2; p++) begin
                run_case(l, p, 1'b1, 1'b1, 1'b1, 1'b1, 3 * (l * (p + 1) + 1) + 4);
                run_case(l, p, 1'b1, 1'b1, 1'b1, 1'b0, 3 * (l * (p + 1) + 1) + 4);
            end
        run_case(3, 1, 1'b0, 1'b1, 1'b1, 1'b1, 14);

        // R9 and R2: load write while running, enable while running, load while stopped
        trig_en = 1'b0; irq_mask = 1'b0; stall_en = 1'b0;
        arm(5, 0, 1'b1);
        step(); step();
        chk(cnt == 16'd3, "R3 before load write", int'(cnt), 3);
        load_val = 16'd9; load_wr = 1'b1;
        step();
        load_wr = 1'b0;
        chk(cnt == 16'd9, "R9 load while running", int'(cnt), 9);
        step();
        chk(cnt == 16'd8, "R9 continue after load", int'(cnt), 8);
        load_val = 16'd20; en_wr = 1'b1; en_val = 1'b1;
        step();
        en_wr = 1'b0;
        chk(cnt == 16'd7 && run == 1'b1, "R2 enable while running ignored", int'(cnt), 7);
        stop_clear();
        load_val = 16'd30; load_wr = 1'b1;
        step();
        load_wr = 1'b0;
        chk(cnt == 16'd7, "R9 load while stopped ignored", int'(cnt), 7);

        // R9: load write restarts the prescaler
        arm(5, 2, 1'b1);
        step();
        load_val = 16'd7; load_wr = 1'b1;
        step();
        load_wr = 1'b0;
        chk(cnt == 16'd7, "R9 prescaled load k0", int'(cnt), 7);
        step();
        chk(cnt == 16'd7, "R9 prescaled load k1", int'(cnt), 7);
        step();
        chk(cnt == 16'd7, "R9 prescaled load k2", int'(cnt), 7);
        step();
        chk(cnt == 16'd6, "R9 prescaled load k3", int'(cnt), 6);
        stop_clear();

        // R6: clear colliding with a timeout
        trig_en = 1'b1;
        arm(2, 0, 1'b1);
        step();
        chk(cnt == 16'd1, "R3 count before collision", int'(cnt), 1);
        clr = 1'b1;
        step();
        clr = 1'b0;
        chk(raw == 1'b1, "R6 timeout beats clear", int'(raw), 1);
        chk(trig == 1'b1 && cnt == 16'd0, "R8 trigger at collision", int'(trig), 1);
        clr = 1'b1;
        step();
        clr = 1'b0;
        chk(raw == 1'b0 && cnt == 16'd2, "R6 later clear", int'(raw), 0);
        stop_clear();

        // R7: mask toggles while the flag is set
        trig_en = 1'b0;
        arm(1, 0, 1'b0);
        step();
        irq_mask = 1'b0;
        #1;
        chk(raw == 1'b1 && irq == 1'b0 && masked == 1'b0, "R7 masked off", int'(irq), 0);
        irq_mask = 1'b1;
        #1;
        chk(irq == 1'b1 && masked == 1'b1, "R7 masked on", int'(irq), 1);
        chk(run == 1'b0, "R5 single run cleared", int'(run), 0);
        stop_clear();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule